// File: doc/BRIEF.md
# Field Memory Read Address Controller

This block produces the read address for a field memory that is organised as lines of words. The address is split into a line part (X) and a word-within-line part (Y). A mode pin picks one of two modes. In sequential mode the address steps forward on each read clock while reads are enabled. In block-access mode the sequential controls have no effect, and the block only gates the data-output enable from the read enable.

In sequential mode each clock edge is one of four cycle kinds. A normal read steps the pointer. A load cycle shifts in one bit of a new line address, MSB first, from a serial pin. There are also two single-edge reset cycles. One reset returns the line to zero and the other moves to the next line. The load-enable pin has a second use: during a reset cycle it selects the return-to-zero reset. Moving to a new line therefore costs one clock, not a long run of read clocks. Any change of line also sets Y to zero, so the next read starts at the first word of the selected line.

All control pins here are plain levels that are sampled on the clock. There is no data stream, so no valid/ready handshake is present. Back-pressure on the read pointer is given only by holding `rd_en_n` high.

Top module: `fmem_rd_addr_ctrl`

## Requirements
- R1: While `rst_n` is low, and after it rises, `x_addr` and `y_addr` are 0.
- R2: With `blk_mode`=0, `rst_cyc`=0, `ld_en_rx`=0 and `rd_en_n`=0, each rising clock edge raises `y_addr` by one. `x_addr` is unchanged while `y_addr` is below WORDS-1.
- R3: With `blk_mode`=0 and `rd_en_n`=1 and no reset or load cycle, `x_addr` and `y_addr` hold over any number of clocks.
- R4: A read at `y_addr`=WORDS-1 sets `y_addr` to 0 and moves `x_addr` to the next line. The next line after LINES-1 is 0.
- R5: A load is `rst_cyc`=0 with `ld_en_rx`=1 for X_W consecutive clocks, one bit of `ser_addr` per clock, MSB first. On the X_W-th edge `x_addr` takes the shifted value and `y_addr` becomes 0. Before that edge neither output changes. A run that ends early is discarded, and the next load starts again from its first bit.
- R6: A reset cycle (`rst_cyc`=1) with `ld_en_rx`=1 sets `x_addr` and `y_addr` to 0 on that single edge, whatever the level of `line_inc`.
- R7: A reset cycle with `line_inc`=1 and `ld_en_rx`=0 moves `x_addr` to the next line (LINES-1 wraps to 0) and sets `y_addr` to 0.
- R8: A reset cycle with `line_inc`=0 and `ld_en_rx`=0 sets `y_addr` to 0 and leaves `x_addr` unchanged.
- R9: With `blk_mode`=1, the clock, `rst_cyc`, `line_inc`, `ld_en_rx` and `ser_addr` have no effect on `x_addr` or `y_addr`, and `dout_en` equals the inverse of `rd_en_n`.
- R10: With `blk_mode`=0, `dout_en` is 1 exactly when `rd_en_n`=0, `rst_cyc`=0 and `ld_en_rx`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Read clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| blk_mode | input | 1 | 0 = sequential mode, 1 = block-access mode |
| rd_en_n | input | 1 | Active-low read enable |
| rst_cyc | input | 1 | High marks a reset cycle |
| line_inc | input | 1 | In a reset cycle, step to the next line |
| ld_en_rx | input | 1 | Load enable; in a reset cycle, return line to zero |
| ser_addr | input | 1 | Serial line address bit, MSB first |
| x_addr | output | X_W | Current line address |
| y_addr | output | Y_W | Current word-within-line address |
| dout_en | output | 1 | Data-output enable |

## Verification
The bench steps across the end of a line and across the end of the field. A design with an off-by-one wrap would report word WORDS or line LINES, or would fail to clear Y. It starts a load, abandons it after two bits, and then loads a full address. A shift counter that is not cleared on the break would latch a mixed value early. It drives a reset cycle with both `line_inc` and `ld_en_rx` high, where the wrong priority would step the line instead of clearing it. It also holds every sequential control active in block-access mode to show that the pointer stays frozen and the output enable follows only `rd_en_n`.

// File: rtl/fmra_pkg.sv
package fmra_pkg;
  typedef enum logic [2:0] {
    CYC_HOLD     = 3'd0,
    CYC_READ     = 3'd1,
    CYC_LOAD     = 3'd2,
    CYC_RST_ZERO = 3'd3,
    CYC_RST_INC  = 3'd4,
    CYC_RST_Y    = 3'd5
  } cyc_e;
endpackage

// File: rtl/fmra_decode.sv
module fmra_decode
  import fmra_pkg::*;
(
  input  logic blk_mode,
  input  logic rd_en_n,
  input  logic rst_cyc,
  input  logic line_inc,
  input  logic ld_en_rx,
  output cyc_e cyc,
  output logic dout_en
);
  always_comb begin
    if (blk_mode)          cyc = CYC_HOLD;
    else if (rst_cyc) begin
      if (ld_en_rx)        cyc = CYC_RST_ZERO;
      else if (line_inc)   cyc = CYC_RST_INC;
      else                 cyc = CYC_RST_Y;
    end
    else if (ld_en_rx)     cyc = CYC_LOAD;
    else if (!rd_en_n)     cyc = CYC_READ;
    else                   cyc = CYC_HOLD;
  end

  assign dout_en = blk_mode ? !rd_en_n : (cyc == CYC_READ);
endmodule

// File: rtl/fmra_line_load.sv
module fmra_line_load
  import fmra_pkg::*;
#(
  parameter int X_W = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           blk_mode,
  input  cyc_e           cyc,
  input  logic           ser_addr,
  output logic           load_done,
  output logic [X_W-1:0] load_val
);
  localparam int CNT_W = $clog2(X_W + 1);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(X_W - 1);

  logic [X_W-1:0]   shreg;
  logic [CNT_W-1:0] cnt;
  logic             shifting;

  assign shifting  = (cyc == CYC_LOAD);
  assign load_done = shifting && (cnt == LAST_BIT);
  assign load_val  = {shreg[X_W-2:0], ser_addr};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg <= '0;
      cnt   <= '0;
    end else if (blk_mode) begin
      shreg <= shreg;
      cnt   <= cnt;
    end else if (shifting) begin
      shreg <= load_val;
      cnt   <= load_done ? '0 : cnt + 1'b1;
    end else begin
      cnt   <= '0;
    end
  end

  // R5: the bit counter never runs past the last address bit
  a_r5_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= LAST_BIT);

  // R5: a broken load sequence restarts from the first bit
  a_r5_abort_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (!blk_mode && !shifting) |=> cnt == '0);
endmodule

// File: rtl/fmra_pointer.sv
module fmra_pointer
  import fmra_pkg::*;
#(
  parameter int X_W   = 4,
  parameter int Y_W   = 4,
  parameter int LINES = 12,
  parameter int WORDS = 10
) (
  input  logic           clk,
  input  logic           rst_n,
  input  cyc_e           cyc,
  input  logic           load_done,
  input  logic [X_W-1:0] load_val,
  output logic [X_W-1:0] x_addr,
  output logic [Y_W-1:0] y_addr
);
  localparam logic [X_W-1:0] LAST_LINE = X_W'(LINES - 1);
  localparam logic [Y_W-1:0] LAST_WORD = Y_W'(WORDS - 1);

  logic [X_W-1:0] next_line;
  assign next_line = (x_addr >= LAST_LINE) ? '0 : x_addr + 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      x_addr <= '0;
      y_addr <= '0;
    end else if (load_done) begin
      x_addr <= load_val;
      y_addr <= '0;
    end else begin
      unique case (cyc)
        CYC_READ: begin
          if (y_addr == LAST_WORD) begin
            y_addr <= '0;
            x_addr <= next_line;
          end else begin
            y_addr <= y_addr + 1'b1;
          end
        end
        CYC_RST_ZERO: begin
          x_addr <= '0;
          y_addr <= '0;
        end
        CYC_RST_INC: begin
          x_addr <= next_line;
          y_addr <= '0;
        end
        CYC_RST_Y: y_addr <= '0;
        default: ;
      endcase
    end
  end

  a_r2_step: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc == CYC_READ && y_addr != LAST_WORD) |=>
      (y_addr == $past(y_addr) + Y_W'(1)) && $stable(x_addr));

  a_r4_wrap_y: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc == CYC_READ && y_addr == LAST_WORD) |=> y_addr == '0);

  a_r6_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc == CYC_RST_ZERO) |=> (x_addr == '0) && (y_addr == '0));

  a_r8_y_only: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc == CYC_RST_Y) |=> (y_addr == '0) && $stable(x_addr));

  a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc == CYC_HOLD) |=> $stable(x_addr) && $stable(y_addr));

  a_r4_line_range: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc == CYC_READ && x_addr < LAST_LINE) |=> x_addr <= LAST_LINE);
endmodule

// File: rtl/fmem_rd_addr_ctrl.sv
module fmem_rd_addr_ctrl
  import fmra_pkg::*;
#(
  parameter int X_W   = 4,
  parameter int Y_W   = 4,
  parameter int LINES = 12,
  parameter int WORDS = 10
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           blk_mode,
  input  logic           rd_en_n,
  input  logic           rst_cyc,
  input  logic           line_inc,
  input  logic           ld_en_rx,
  input  logic           ser_addr,
  output logic [X_W-1:0] x_addr,
  output logic [Y_W-1:0] y_addr,
  output logic           dout_en
);
  cyc_e           cyc;
  logic           load_done;
  logic [X_W-1:0] load_val;

  fmra_decode u_decode (
    .blk_mode (blk_mode),
    .rd_en_n  (rd_en_n),
    .rst_cyc  (rst_cyc),
    .line_inc (line_inc),
    .ld_en_rx (ld_en_rx),
    .cyc      (cyc),
    .dout_en  (dout_en)
  );

  fmra_line_load #(.X_W(X_W)) u_load (
    .clk       (clk),
    .rst_n     (rst_n),
    .blk_mode  (blk_mode),
    .cyc       (cyc),
    .ser_addr  (ser_addr),
    .load_done (load_done),
    .load_val  (load_val)
  );

  fmra_pointer #(.X_W(X_W), .Y_W(Y_W), .LINES(LINES), .WORDS(WORDS)) u_ptr (
    .clk       (clk),
    .rst_n     (rst_n),
    .cyc       (cyc),
    .load_done (load_done),
    .load_val  (load_val),
    .x_addr    (x_addr),
    .y_addr    (y_addr)
  );

  // R9: block-access mode freezes the address
  a_r9_block_freeze: assert property (@(posedge clk) disable iff (!rst_n)
    blk_mode |=> $stable(x_addr) && $stable(y_addr));

  // R10: output enable never asserted during a sequential reset cycle
  a_r10_no_en_in_reset: assert property (@(posedge clk) disable iff (!rst_n)
    (!blk_mode && rst_cyc) |-> !dout_en);
endmodule

// File: tb/fmem_rd_addr_ctrl_tb.sv
module fmem_rd_addr_ctrl_tb;
  localparam int CLK_PERIOD = 10;
  localparam int X_W = 4;
  localparam int Y_W = 4;
  localparam int LINES = 12;
  localparam int WORDS = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic blk_mode = 1'b0, rd_en_n = 1'b1, rst_cyc = 1'b0;
  logic line_inc = 1'b0, ld_en_rx = 1'b0, ser_addr = 1'b0;
  logic [X_W-1:0] x_addr;
  logic [Y_W-1:0] y_addr;
  logic dout_en;

  int n_tests = 0;
  int n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  fmem_rd_addr_ctrl #(.X_W(X_W), .Y_W(Y_W), .LINES(LINES), .WORDS(WORDS)) u_dut (
    .clk(clk), .rst_n(rst_n), .blk_mode(blk_mode), .rd_en_n(rd_en_n),
    .rst_cyc(rst_cyc), .line_inc(line_inc), .ld_en_rx(ld_en_rx),
    .ser_addr(ser_addr), .x_addr(x_addr), .y_addr(y_addr), .dout_en(dout_en)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // drive at falling edge, clock one rising edge, return at next falling edge
  task automatic step(input logic blk, input logic ren, input logic rr,
                      input logic inc, input logic ld, input logic bit_in);
    blk_mode = blk; rd_en_n = ren; rst_cyc = rr;
    line_inc = inc; ld_en_rx = ld; ser_addr = bit_in;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic idle();
    step(1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic reads(input int n);
    for (int i = 0; i < n; i++) step(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic load_bits(input int val, input int nbits);
    for (int i = 0; i < nbits; i++)
      step(1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'(val >> (X_W - 1 - i)));
  endtask

  task automatic t_reset();
    chk("R1 x in reset", int'(x_addr), 0);
    chk("R1 y in reset", int'(y_addr), 0);
    rst_n = 1'b1;
    idle();
    chk("R1 x after reset", int'(x_addr), 0);
    chk("R1 y after reset", int'(y_addr), 0);
  endtask

  task automatic t_read_and_hold();
    reads(3);
    chk("R2 y after 3 reads", int'(y_addr), 3);
    chk("R2 x unchanged", int'(x_addr), 0);
    idle(); idle(); idle();
    chk("R3 y held", int'(y_addr), 3);
    chk("R3 x held", int'(x_addr), 0);
  endtask

  task automatic t_line_wrap();
    reads(6);
    chk("R2 y at last word", int'(y_addr), WORDS - 1);
    chk("R2 x before wrap", int'(x_addr), 0);
    reads(1);
    chk("R4 y wrapped", int'(y_addr), 0);
    chk("R4 x stepped", int'(x_addr), 1);
  endtask

  task automatic t_rst_y_and_inc();
    reads(2);
    step(1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0);
    chk("R8 y cleared", int'(y_addr), 0);
    chk("R8 x kept", int'(x_addr), 1);
    reads(4);
    step(1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0);
    chk("R7 x next line", int'(x_addr), 2);
    chk("R7 y cleared", int'(y_addr), 0);
  endtask

  task automatic t_load();
    reads(2);
    load_bits(11, 3);
    chk("R5 x before last bit", int'(x_addr), 2);
    chk("R5 y before last bit", int'(y_addr), 2);
    load_bits(11 << 3, 1);
    chk("R5 x loaded", int'(x_addr), 11);
    chk("R5 y cleared", int'(y_addr), 0);
  endtask

  task automatic t_field_wrap();
    reads(WORDS);
    chk("R4 x wraps at field end", int'(x_addr), 0);
    chk("R4 y wraps at field end", int'(y_addr), 0);
    load_bits(LINES - 1, X_W);
    reads(1);
    step(1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0);
    chk("R7 x wraps to 0", int'(x_addr), 0);
    chk("R7 y cleared at wrap", int'(y_addr), 0);
  endtask

  task automatic t_abort();
    step(1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0); // x = 1
    load_bits(15, 2);
    idle();
    chk("R5 aborted load leaves x", int'(x_addr), 1);
    load_bits(5, 2);
    chk("R5 restart not early", int'(x_addr), 1);
    load_bits(5 << 2, 2);
    chk("R5 restart loads value", int'(x_addr), 5);
  endtask

  task automatic t_rst_zero();
    reads(3);
    step(1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0);
    chk("R6 x zero", int'(x_addr), 0);
    chk("R6 y zero", int'(y_addr), 0);
    step(1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0);
    reads(1);
    step(1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0);
    chk("R6 both high gives x zero", int'(x_addr), 0);
    chk("R6 both high gives y zero", int'(y_addr), 0);
  endtask

  task automatic t_block();
    load_bits(5, X_W);
    reads(2);
    step(1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1);
    step(1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0);
    step(1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1);
    chk("R9 x frozen", int'(x_addr), 5);
    chk("R9 y frozen", int'(y_addr), 2);
    chk("R9 dout_en with rd_en_n low", int'(dout_en), 1);
    rd_en_n = 1'b1; #1;
    chk("R9 dout_en with rd_en_n high", int'(dout_en), 0);
    step(1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0);
    step(1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
    load_bits(3, X_W);
    chk("R9 no partial load in block mode", int'(x_addr), 3);
  endtask

  task automatic t_dout_en();
    blk_mode = 0; rd_en_n = 0; rst_cyc = 0; ld_en_rx = 0; line_inc = 0; #1;
    chk("R10 enabled on read", int'(dout_en), 1);
    rst_cyc = 1; #1;
    chk("R10 off in reset cycle", int'(dout_en), 0);
    rst_cyc = 0; ld_en_rx = 1; #1;
    chk("R10 off in load cycle", int'(dout_en), 0);
    ld_en_rx = 0; rd_en_n = 1; #1;
    chk("R10 off when read disabled", int'(dout_en), 0);
  endtask

  initial begin
    @(negedge clk);
    @(negedge clk);
    t_reset();
    t_read_and_hold();
    t_line_wrap();
    t_rst_y_and_inc();
    t_load();
    t_field_wrap();
    t_abort();
    t_rst_zero();
    t_block();
    t_dout_en();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule